// File: doc/BRIEF.md
# Escape-Stuffing Byte Framer

This block assembles a byte-oriented link frame from two independent input streams: a header stream and a body stream. Each stream uses a valid/ready/last handshake. The output is a single valid/ready byte stream, with an end-of-frame flag on the final byte. A frame is emitted in a fixed order:

1. a synchronisation byte
2. a start-of-header byte
3. the header bytes, copied verbatim
4. a start-of-text byte
5. the body bytes
6. an end-of-text byte, which closes the frame

The closing byte must stay unambiguous to a receiver. For that reason, every body byte whose value equals the terminator or the escape code is preceded by one inserted escape byte. The escape byte is also escaped, so the receiver can drop the first escape of any pair and keep the byte that follows it.

Body beats carry a `body_nil` qualifier. A frame with no text is sent as a single beat with `body_nil` and `body_last` both set. That beat is consumed and produces no output byte. The control values are parameters, with the defaults listed below. Back-pressure on the output stalls the whole sequencer without losing or repeating any byte.

Top module: `dle_framer`

## Requirements
- R1: After reset, and until a header byte is offered, `out_valid`, `hdr_ready` and `body_ready` are all low and no byte is emitted.
- R2: Each frame is emitted in this order: 0x16 (sync), 0x01 (start of header), the header bytes, 0x02 (start of text), the stuffed body, 0x03 (end of text).
- R3: Header bytes are copied unchanged, with no escape inserted, even when they equal 0x03 or 0x10. The header ends with the beat that carries `hdr_last`.
- R4: A body byte equal to 0x03 is emitted as 0x10 followed by 0x03.
- R5: A body byte equal to 0x10 is emitted as 0x10 followed by 0x10.
- R6: While an inserted escape byte is presented, `body_ready` is low. A non-nil body byte is accepted only in the cycle in which that same byte is accepted at the output, so the escape and the original byte occupy consecutive accepted output slots.
- R7: `out_eof` is high only on the 0x03 terminator byte. After the terminator is accepted, the next accepted byte is the 0x16 sync byte of a new frame.
- R8: A body beat with `body_nil` high and `body_last` high is consumed without emitting a byte. The frame then carries 0x02 immediately followed by 0x03.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_eof` hold their values into the next cycle. No byte is dropped or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Header byte available |
| hdr_ready | output | 1 | Header byte taken this cycle when valid |
| hdr_data | input | W | Header byte |
| hdr_last | input | 1 | Final header byte of the frame |
| body_valid | input | 1 | Body beat available |
| body_ready | output | 1 | Body beat taken this cycle when valid |
| body_data | input | W | Body byte |
| body_last | input | 1 | Final body beat of the frame |
| body_nil | input | 1 | Beat carries no byte (empty body); must come with body_last |
| out_valid | output | 1 | Output byte available |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | W | Output byte |
| out_eof | output | 1 | Output byte is the frame terminator |

## Verification
The in-RTL properties check the following on every cycle:

- the output is held under back-pressure
- a body byte is taken only together with its own emission
- the escape state is entered only after an escape byte has been accepted, and carries only a terminator or escape value
- the sequencer returns to sync after the terminator

The framing order, header transparency, the stuffing of specific byte patterns and the empty-body frame can only be shown by the bench's scenarios. In those scenarios, a behavioural reference model predicts every output byte under both steady and random output readiness.

// File: rtl/dle_framer_pkg.sv
package dle_framer_pkg;

   typedef enum logic [2:0] {
      ST_SYNC = 3'd0,
      ST_SOH  = 3'd1,
      ST_HDR  = 3'd2,
      ST_STX  = 3'd3,
      ST_BODY = 3'd4,
      ST_ESC  = 3'd5,
      ST_END  = 3'd6
   } frm_state_e;

endpackage

// File: rtl/dle_code_match.sv
module dle_code_match #(
   parameter int W = 8,
   parameter int NUM_CODES = 2,
   parameter logic [NUM_CODES*W-1:0] CODES = {8'h03, 8'h10}
) (
   input  logic [W-1:0] din,
   output logic         hit
);
   logic [NUM_CODES-1:0] eq;

   generate
      if (NUM_CODES < 1) begin : g_bad
         $error("dle_code_match: NUM_CODES must be at least 1");
      end
      for (genvar i = 0; i < NUM_CODES; i++) begin : g_cmp
         assign eq[i] = (din == CODES[i*W +: W]);
      end
   endgenerate

   assign hit = |eq;
endmodule

// File: rtl/dle_frame_seq.sv
module dle_frame_seq
   import dle_framer_pkg::*;
#(
   parameter int W = 8,
   parameter logic [W-1:0] C_SYN = 'h16,
   parameter logic [W-1:0] C_SOH = 'h01,
   parameter logic [W-1:0] C_STX = 'h02,
   parameter logic [W-1:0] C_ETX = 'h03,
   parameter logic [W-1:0] C_DLE = 'h10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hdr_valid,
   input  logic         hdr_last,
   input  logic [W-1:0] hdr_data,
   output logic         hdr_ready,
   input  logic         body_valid,
   input  logic         body_last,
   input  logic         body_nil,
   input  logic [W-1:0] body_data,
   output logic         body_ready,
   input  logic         esc_hit,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] out_data,
   output logic         out_eof
);
   frm_state_e state, state_nxt;
   logic       fire;

   assign fire = out_valid & out_ready;

   always_comb begin
      out_valid  = 1'b0;
      out_data   = C_SYN;
      out_eof    = 1'b0;
      hdr_ready  = 1'b0;
      body_ready = 1'b0;
      state_nxt  = state;
      unique case (state)
         ST_SYNC: begin
            out_valid = hdr_valid;
            out_data  = C_SYN;
            if (fire) state_nxt = ST_SOH;
         end
         ST_SOH: begin
            out_valid = 1'b1;
            out_data  = C_SOH;
            if (fire) state_nxt = ST_HDR;
         end
         ST_HDR: begin
            out_valid = hdr_valid;
            out_data  = hdr_data;
            hdr_ready = out_ready;
            if (fire && hdr_last) state_nxt = ST_STX;
         end
         ST_STX: begin
            out_valid = 1'b1;
            out_data  = C_STX;
            if (fire) state_nxt = ST_BODY;
         end
         ST_BODY: begin
            if (body_valid && body_nil) begin
               body_ready = 1'b1;
               if (body_last) state_nxt = ST_END;
            end else if (body_valid && esc_hit) begin
               out_valid = 1'b1;
               out_data  = C_DLE;
               if (fire) state_nxt = ST_ESC;
            end else begin
               out_valid  = body_valid;
               out_data   = body_data;
               body_ready = out_ready;
               if (fire && body_last) state_nxt = ST_END;
            end
         end
         ST_ESC: begin
            out_valid  = body_valid;
            out_data   = body_data;
            body_ready = out_ready;
            if (fire) state_nxt = body_last ? ST_END : ST_BODY;
         end
         ST_END: begin
            out_valid = 1'b1;
            out_data  = C_ETX;
            out_eof   = 1'b1;
            if (fire) state_nxt = ST_SYNC;
         end
         default: state_nxt = ST_SYNC;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= ST_SYNC;
      else        state <= state_nxt;
   end

   // R6: the escape state is entered only after an accepted escape byte
   a_r6_esc_after_dle: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ESC) |-> ($past(fire && out_data == C_DLE) || $past(state == ST_ESC)));

   // R4, R5: a byte emitted after an escape is a terminator or escape value
   a_r4_esc_payload: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ESC && out_valid) |-> esc_hit);

   // R6: a body byte is taken only with its own emission
   a_r6_one_to_one: assert property (@(posedge clk) disable iff (!rst_n)
      (body_valid && body_ready && !body_nil) |-> (fire && out_data == body_data));

   // R7: the terminator closes the frame, and the next frame restarts at sync
   a_r7_eof_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && out_eof) |=> (state == ST_SYNC));
endmodule

// File: rtl/dle_framer.sv
module dle_framer #(
   parameter int W = 8,
   parameter logic [W-1:0] C_SYN = 'h16,
   parameter logic [W-1:0] C_SOH = 'h01,
   parameter logic [W-1:0] C_STX = 'h02,
   parameter logic [W-1:0] C_ETX = 'h03,
   parameter logic [W-1:0] C_DLE = 'h10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hdr_valid,
   output logic         hdr_ready,
   input  logic [W-1:0] hdr_data,
   input  logic         hdr_last,
   input  logic         body_valid,
   output logic         body_ready,
   input  logic [W-1:0] body_data,
   input  logic         body_last,
   input  logic         body_nil,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] out_data,
   output logic         out_eof
);
   localparam int NUM_ESC = 2;
   localparam logic [NUM_ESC*W-1:0] ESC_SET = {C_ETX, C_DLE};

   generate
      if (W < 2) begin : g_bad_w
         $error("dle_framer: W must be at least 2");
      end
      if (C_ETX == C_DLE) begin : g_bad_esc
         $error("dle_framer: terminator and escape codes must differ");
      end
   endgenerate

   logic esc_hit;

   dle_code_match #(
      .W(W), .NUM_CODES(NUM_ESC), .CODES(ESC_SET)
   ) u_match (
      .din(body_data),
      .hit(esc_hit)
   );

   dle_frame_seq #(
      .W(W), .C_SYN(C_SYN), .C_SOH(C_SOH), .C_STX(C_STX),
      .C_ETX(C_ETX), .C_DLE(C_DLE)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .hdr_valid(hdr_valid), .hdr_last(hdr_last), .hdr_data(hdr_data),
      .hdr_ready(hdr_ready),
      .body_valid(body_valid), .body_last(body_last), .body_nil(body_nil),
      .body_data(body_data), .body_ready(body_ready),
      .esc_hit(esc_hit),
      .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .out_eof(out_eof)
   );

   // R9: a stalled output byte is held unchanged
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_eof)));
endmodule

// File: tb/dle_framer_bench.sv
module dle_framer_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hdr_valid = 1'b0, hdr_last = 1'b0;
   logic [7:0] hdr_data = 8'h00;
   logic       body_valid = 1'b0, body_last = 1'b0, body_nil = 1'b0;
   logic [7:0] body_data = 8'h00;
   logic       out_ready = 1'b0;
   logic       hdr_ready, body_ready, out_valid, out_eof;
   logic [7:0] out_data;

   int vectors = 0;
   int miscompares = 0;
   int ready_mode = 1;       // 1: always ready, 0: random
   bit timed_out = 1'b0;

   logic [8:0] exp_q[$];     // {eof, byte}
   logic [7:0] hq[$];
   logic [7:0] bq[$];

   always #4 clk = ~clk;     // 125 MHz

   dle_framer u_dle_framer (
      .clk(clk), .rst_n(rst_n),
      .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_data(hdr_data), .hdr_last(hdr_last),
      .body_valid(body_valid), .body_ready(body_ready), .body_data(body_data),
      .body_last(body_last), .body_nil(body_nil),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_eof(out_eof)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // output readiness driver
   always @(posedge clk) begin
      #1;
      out_ready <= (ready_mode == 1) ? 1'b1 : (($urandom % 3) != 0);
   end

   // monitor: compares every accepted byte against the reference model
   logic       pv_stall = 1'b0;
   logic [8:0] pv_word = 9'h0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (pv_stall)   // R9
            check(out_valid && {out_eof, out_data} == pv_word, "R9 hold",
                  {out_valid, out_eof, out_data}, {1'b1, pv_word});
         if (body_valid && body_ready && !body_nil)   // R6
            check(out_valid && out_ready && out_data == body_data, "R6 one-to-one",
                  out_data, body_data);
         if (out_valid && out_ready) begin
            if (exp_q.size() == 0)
               check(1'b0, "R2 unexpected byte", {out_eof, out_data}, 0);
            else begin
               logic [8:0] e;
               e = exp_q.pop_front();
               check({out_eof, out_data} == e, "R2-stream/R4/R5/R7 byte",
                     {out_eof, out_data}, e);
            end
         end
         pv_stall = out_valid && !out_ready;
         pv_word  = {out_eof, out_data};
      end
   end

   task automatic drive_hdr();
      for (int i = 0; i < hq.size(); i++) begin
         hdr_valid = 1'b1;
         hdr_data  = hq[i];
         hdr_last  = (i == hq.size() - 1);
         @(negedge clk);
         while (!hdr_ready) @(negedge clk);
         @(posedge clk); #1;
      end
      hdr_valid = 1'b0;
      hdr_last  = 1'b0;
   endtask

   task automatic drive_body();
      if (bq.size() == 0) begin   // R8 empty body beat
         body_valid = 1'b1; body_nil = 1'b1; body_last = 1'b1; body_data = 8'h00;
         @(negedge clk);
         while (!body_ready) @(negedge clk);
         @(posedge clk); #1;
      end else begin
         for (int i = 0; i < bq.size(); i++) begin
            body_valid = 1'b1; body_nil = 1'b0;
            body_data  = bq[i];
            body_last  = (i == bq.size() - 1);
            @(negedge clk);
            while (!body_ready) @(negedge clk);
            @(posedge clk); #1;
         end
      end
      body_valid = 1'b0; body_nil = 1'b0; body_last = 1'b0;
   endtask

   // reference model: R2 order, R3 plain header, R4/R5 escapes, R7 eof, R8 empty
   task automatic send_frame();
      exp_q.push_back({1'b0, 8'h16});
      exp_q.push_back({1'b0, 8'h01});
      foreach (hq[i]) exp_q.push_back({1'b0, hq[i]});
      exp_q.push_back({1'b0, 8'h02});
      foreach (bq[i]) begin
         if (bq[i] == 8'h03 || bq[i] == 8'h10) exp_q.push_back({1'b0, 8'h10});
         exp_q.push_back({1'b0, bq[i]});
      end
      exp_q.push_back({1'b1, 8'h03});
      fork
         drive_hdr();
         drive_body();
      join
   endtask

   task automatic run_all();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      repeat (4) begin   // R1: idle with no header offered
         @(negedge clk);
         check(!out_valid && !hdr_ready && !body_ready, "R1 idle",
               {out_valid, hdr_ready, body_ready}, 0);
      end
      @(posedge clk); #1;
      hq = '{8'hA0, 8'hA1}; bq = '{8'h11, 8'h22, 8'h33};
      send_frame();                                   // R2 plain frame
      hq = '{8'h03, 8'h10}; bq = '{8'h03, 8'h10, 8'h44, 8'h10, 8'h03};
      send_frame();                                   // R3, R4, R5
      hq = '{8'h5A}; bq = '{};
      send_frame();                                   // R8 empty body
      hq = '{8'h01}; bq = '{8'h10};
      send_frame();                                   // R5 single escaped byte
      ready_mode = 0;                                 // R9 back-pressure
      hq = '{8'h03}; bq = '{};
      send_frame();                                   // R8 under stall
      for (int f = 0; f < 40; f++) begin
         hq = '{}; bq = '{};
         for (int i = 0; i < 1 + ($urandom % 4); i++) hq.push_back($urandom);
         for (int i = 0; i < ($urandom % 7); i++) begin
            int r;
            r = $urandom % 4;
            bq.push_back(r == 0 ? 8'h03 : r == 1 ? 8'h10 : 8'($urandom));
         end
         send_frame();
      end
      repeat (20) @(posedge clk);
      check(exp_q.size() == 0, "R2 all bytes emitted", exp_q.size(), 0);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (100000) @(posedge clk);
            timed_out = 1'b1;
         end
      join_any
      if (timed_out) check(1'b0, "watchdog", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule